// File: doc/BRIEF.md
# Interrupt Source Aggregator with Wake-Up Path

This block collects the interrupt sources of a small 8-bit controller and reduces them to two outputs: an interrupt request for the CPU and a wake-from-sleep request. The sources are:

- an external pin whose active edge can be selected;
- a one-cycle timer rollover pulse;
- a one-cycle port-change pulse;
- a parameterised set of peripheral set pulses.

Each source latches a sticky flag. Software reads and writes the flags through a small register port. Each flag has its own enable bit, and the peripheral group passes through a further group enable.

The wake request uses only the per-source gating. The interrupt request additionally needs the global enable. When the CPU accepts an interrupt (`irq_ack`), the global enable drops, so a handler is not re-entered. The block also drives the fixed service address. The CPU branches there only when the global enable is set. Otherwise a woken CPU carries on in line.

Register map, addressed through `addr`:

| Address | Bits | Contents |
|---|---|---|
| 0 | 7 | global enable |
| 0 | 6 | peripheral group enable |
| 0 | 5 | external enable |
| 0 | 4 | timer enable |
| 0 | 3 | port-change enable |
| 0 | 2 | timer flag |
| 0 | 1 | external flag |
| 0 | 0 | port-change flag |
| 1 | 0 | edge polarity (1 = rising, 0 = falling); other bits read 0 |
| 2 | i | peripheral flag i |
| 3 | i | peripheral enable i |

At addresses 2 and 3, bits above `NUM_PERIPH-1` read 0. A write stores `wr_data` into the addressed register at the clock edge. Reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four registers read 0, `irq_req` is 0 and `wake_req` is 0.
- R2: The external flag (address 0, bit 1) is set by the edge of `ext_pin` that the polarity bit selects (address 1, bit 0: 1 = rising, 0 = falling). The opposite edge does not set it. The flag reads 1 from the third rising clock edge after the pin changes (two synchronizer stages plus one edge stage).
- R3: A selected edge sets the external flag even when the external enable is 0.
- R4: A hardware event never clears a flag. Only a register write clears it. A write stores exactly the written bits.
- R5: When a write that clears a flag and a hardware set event for that flag fall in the same cycle, the flag ends at 1.
- R6: A `tmr_ovf` pulse sets the timer flag (address 0, bit 2). A `port_chg` pulse sets the port-change flag (address 0, bit 0). A pulse on `periph_set[i]` sets peripheral flag i (address 2, bit i).
- R7: `irq_req` is the global enable ANDed with the OR of all enabled sources. An enabled source is: external flag AND external enable, timer flag AND timer enable, port-change flag AND port-change enable, or group enable AND any (peripheral flag i AND peripheral enable i).
- R8: `wake_req` is the same OR of enabled sources without the global enable. It can therefore be 1 while the global enable is 0.
- R9: `irq_ack` clears the global enable at the same clock edge. It takes priority over a write that sets the global enable in that cycle.
- R10: While the peripheral group enable is 0, set and enabled peripheral flags cause neither `irq_req` nor `wake_req`.
- R11: `vector_addr` always equals the service address parameter, 0x0004 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer rollover pulse, one cycle |
| port_chg | input | 1 | Port-change pulse, one cycle |
| periph_set | input | NUM_PERIPH | Peripheral flag set pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| irq_ack | input | 1 | CPU accepts the interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake_req | output | 1 | Wake-from-sleep request |
| vector_addr | output | VEC_W | Fixed service address |

## Verification
A flag or enable bit held at a wrong value shows at the ports one cycle later. It appears in `rd_data` for the addressed register and, whenever the matching enable is set, as a wrong `irq_req` or `wake_req` level in that same cycle. A synchronizer fault shows as the external flag appearing a cycle early or late, or on the wrong edge. A lost set/clear priority shows as a flag reading 0 directly after a colliding write. The bench compares every output against a behavioural model on every cycle, so any such divergence is reported in the first cycle it becomes visible.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef struct packed {
        logic gie;
        logic grp_en;
        logic ext_en;
        logic tmr_en;
        logic chg_en;
        logic tmr_f;
        logic ext_f;
        logic chg_f;
        logic pol;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_POL  = 2'd1;
    localparam logic [1:0] ADDR_PFLG = 2'd2;
    localparam logic [1:0] ADDR_PEN  = 2'd3;

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rising,
    output logic edge_hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     cur;

    assign cur = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_hit = rising ? (cur & ~st_q.prev) : (~cur & st_q.prev);

endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import irq_agg_pkg::*;
#(
    parameter int NUM_PERIPH = 6
) (
    input  ctrl_t                 ctrl,
    input  logic [NUM_PERIPH-1:0] pflag,
    input  logic [NUM_PERIPH-1:0] pen,
    output logic                  wake,
    output logic                  irq
);
    logic core_hit;
    logic grp_hit;

    always_comb begin
        core_hit = (ctrl.ext_f & ctrl.ext_en) |
                   (ctrl.tmr_f & ctrl.tmr_en) |
                   (ctrl.chg_f & ctrl.chg_en);
        grp_hit  = ctrl.grp_en & (|(pflag & pen));
        wake     = core_hit | grp_hit;
        irq      = ctrl.gie & wake;
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int               NUM_PERIPH  = 6,
    parameter int               SYNC_STAGES = 2,
    parameter int               VEC_W       = 13,
    parameter logic [VEC_W-1:0] VEC_ADDR    = 13'h0004
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_pin,
    input  logic                  tmr_ovf,
    input  logic                  port_chg,
    input  logic [NUM_PERIPH-1:0] periph_set,
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic                  irq_ack,
    output logic                  irq_req,
    output logic                  wake_req,
    output logic [VEC_W-1:0]      vector_addr
);
    localparam int DATA_W = 8;

    typedef struct packed {
        ctrl_t                 c;
        logic [NUM_PERIPH-1:0] pf;
        logic [NUM_PERIPH-1:0] pe;
    } state_t;

    state_t st_d, st_q;
    logic   ext_edge;

    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .rising   (st_q.c.pol),
        .edge_hit (ext_edge)
    );

    irq_src_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .ctrl  (st_q.c),
        .pflag (st_q.pf),
        .pen   (st_q.pe),
        .wake  (wake_req),
        .irq   (irq_req)
    );

    always_comb begin
        st_d = st_q;
        // software write first; hardware events below override it
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    st_d.c.gie    = wr_data[7];
                    st_d.c.grp_en = wr_data[6];
                    st_d.c.ext_en = wr_data[5];
                    st_d.c.tmr_en = wr_data[4];
                    st_d.c.chg_en = wr_data[3];
                    st_d.c.tmr_f  = wr_data[2];
                    st_d.c.ext_f  = wr_data[1];
                    st_d.c.chg_f  = wr_data[0];
                end
                ADDR_POL:  st_d.c.pol = wr_data[0];
                ADDR_PFLG: st_d.pf    = wr_data[NUM_PERIPH-1:0];
                default:   st_d.pe    = wr_data[NUM_PERIPH-1:0];
            endcase
        end
        if (ext_edge) st_d.c.ext_f = 1'b1;
        if (tmr_ovf)  st_d.c.tmr_f = 1'b1;
        if (port_chg) st_d.c.chg_f = 1'b1;
        st_d.pf = st_d.pf | periph_set;
        if (irq_ack)  st_d.c.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: rd_data = {st_q.c.gie, st_q.c.grp_en, st_q.c.ext_en,
                                  st_q.c.tmr_en, st_q.c.chg_en, st_q.c.tmr_f,
                                  st_q.c.ext_f, st_q.c.chg_f};
            ADDR_POL:  rd_data[0] = st_q.c.pol;
            ADDR_PFLG: rd_data[NUM_PERIPH-1:0] = st_q.pf;
            default:   rd_data[NUM_PERIPH-1:0] = st_q.pe;
        endcase
    end

    assign vector_addr = VEC_ADDR;

    if (NUM_PERIPH > DATA_W) begin : g_bad_width
        initial $error("NUM_PERIPH exceeds register width");
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int               NUM_PERIPH = 6,
    parameter int               VEC_W      = 13,
    parameter logic [VEC_W-1:0] VEC_ADDR   = 13'h0004
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [1:0]            addr,
    input logic                  tmr_ovf,
    input logic                  port_chg,
    input logic [NUM_PERIPH-1:0] periph_set,
    input logic                  irq_ack,
    input logic                  irq_req,
    input logic                  wake_req,
    input logic [VEC_W-1:0]      vector_addr,
    input ctrl_t                 ctrl_q,
    input logic [NUM_PERIPH-1:0] pflag_q
);
    logic no_ctrl_wr;
    assign no_ctrl_wr = !(wr_en && addr == ADDR_CTRL);

    a_r4_ext_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ctrl_wr && ctrl_q.ext_f) |=> ctrl_q.ext_f);

    a_r5_timer_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctrl_q.tmr_f);

    a_r6_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        port_chg |=> ctrl_q.chg_f);

    a_r6_periph_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_set) |=> ((pflag_q & $past(periph_set)) == $past(periph_set)));

    a_r9_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ctrl_q.gie);

    a_r7_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl_q.gie);

    a_r8_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_req);

    always_comb begin
        a_r11_vector_fixed: assert (vector_addr == VEC_ADDR);
    end

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .NUM_PERIPH (NUM_PERIPH),
    .VEC_W      (VEC_W),
    .VEC_ADDR   (VEC_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .tmr_ovf     (tmr_ovf),
    .port_chg    (port_chg),
    .periph_set  (periph_set),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .wake_req    (wake_req),
    .vector_addr (vector_addr),
    .ctrl_q      (st_q.c),
    .pflag_q     (st_q.pf)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_pin = 1'b0, tmr_ovf = 1'b0, port_chg = 1'b0;
    logic [NP-1:0] periph_set = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          irq_ack = 1'b0;
    logic          irq_req, wake_req;
    logic [12:0]   vector_addr;

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    irq_aggregator #(.NUM_PERIPH(NP)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_chg(port_chg), .periph_set(periph_set), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack),
        .irq_req(irq_req), .wake_req(wake_req), .vector_addr(vector_addr)
    );

    // behavioural reference
    bit m_gie, m_grp, m_xe, m_te, m_ce, m_tf, m_xf, m_cf, m_pol;
    bit [NP-1:0] m_pf, m_pe;
    bit h0, h1, h2;

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_gie, m_grp, m_xe, m_te, m_ce, m_tf, m_xf, m_cf, m_pol} = '0;
            m_pf = '0; m_pe = '0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            bit hit;
            hit = m_pol ? (h1 && !h2) : (!h1 && h2);
            if (wr_en) begin
                if (addr == 0) {m_gie, m_grp, m_xe, m_te, m_ce, m_tf, m_xf, m_cf} = wr_data;
                else if (addr == 1) m_pol = wr_data[0];
                else if (addr == 2) m_pf = wr_data[NP-1:0];
                else m_pe = wr_data[NP-1:0];
            end
            if (hit) m_xf = 1;
            if (tmr_ovf) m_tf = 1;
            if (port_chg) m_cf = 1;
            m_pf = m_pf | periph_set;
            if (irq_ack) m_gie = 0;
            h2 = h1; h1 = h0; h0 = ext_pin;
        end
    end

    function automatic bit m_wake();
        return (m_xf && m_xe) || (m_tf && m_te) || (m_cf && m_ce) || (m_grp && |(m_pf & m_pe));
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        logic [7:0] v = '0;
        case (a)
            2'd0: v = {m_gie, m_grp, m_xe, m_te, m_ce, m_tf, m_xf, m_cf};
            2'd1: v[0] = m_pol;
            2'd2: v[NP-1:0] = m_pf;
            default: v[NP-1:0] = m_pe;
        endcase
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq_req == (m_gie && m_wake()), "R7 irq_req", irq_req, m_gie && m_wake());
            check(wake_req == m_wake(), "R8 wake_req", wake_req, m_wake());
            check(rd_data == m_read(addr), addr == 2 ? "R6 periph flags" : "R4 register read",
                  rd_data, m_read(addr));
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(); wr_en = 1; addr = a; wr_data = d;
        step(); wr_en = 0;
    endtask

    task automatic look(input logic [1:0] a);
        step(); addr = a; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            look(a[1:0]);
            check(rd_data == 8'h00, "R1 reset register", rd_data, 0);
        end
        check(irq_req == 0 && wake_req == 0, "R1 reset requests", {irq_req, wake_req}, 0);
        check(vector_addr == 13'h0004, "R11 vector", vector_addr, 4);

        // R2/R3 rising edge, enable off, latency of three edges
        wr(2'd1, 8'h01);
        addr = 2'd0;
        step(); ext_pin = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(rd_data[1] == 0, "R2 flag not yet set", rd_data[1], 0);
        @(posedge clk); @(negedge clk);
        check(rd_data[1] == 1, "R2 R3 flag set after three edges", rd_data[1], 1);
        check(wake_req == 0, "R3 disabled source no wake", wake_req, 0);
        // R4 sticky over time
        repeat (5) step();
        @(negedge clk);
        check(rd_data[1] == 1, "R4 flag sticky", rd_data[1], 1);
        wr(2'd0, 8'h00);
        step(); ext_pin = 0;
        repeat (6) step();
        look(2'd0);
        check(rd_data[1] == 0, "R2 opposite edge ignored", rd_data[1], 0);
        // falling polarity
        wr(2'd1, 8'h00);
        step(); ext_pin = 1;
        repeat (5) step();
        look(2'd0);
        check(rd_data[1] == 0, "R2 rising ignored in falling mode", rd_data[1], 0);
        ext_pin = 0;
        repeat (5) step();
        look(2'd0);
        check(rd_data[1] == 1, "R2 falling edge sets", rd_data[1], 1);

        // R5 clear write colliding with timer set
        step(); wr_en = 1; addr = 0; wr_data = 8'h00; tmr_ovf = 1;
        step(); wr_en = 0; tmr_ovf = 0;
        @(negedge clk);
        check(rd_data[2] == 1 && rd_data[1] == 0, "R5 set wins over clear", rd_data, 8'h04);

        // R6 change and peripheral pulses
        step(); port_chg = 1; periph_set = 6'b100010;
        step(); port_chg = 0; periph_set = '0;
        @(negedge clk);
        check(rd_data[0] == 1, "R6 change flag", rd_data[0], 1);
        look(2'd2);
        check(rd_data == 8'h22, "R6 peripheral flags", rd_data, 8'h22);

        // R10 group gate, R8 wake without gie
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h02);
        @(negedge clk);
        check(wake_req == 0, "R10 group disabled no wake", wake_req, 0);
        wr(2'd0, 8'h40);
        @(negedge clk);
        check(wake_req == 1 && irq_req == 0, "R8 wake without gie", {irq_req, wake_req}, 1);

        // R7 / R9 acceptance beats a gie write
        wr(2'd0, 8'hC0);
        @(negedge clk);
        check(irq_req == 1, "R7 irq with gie", irq_req, 1);
        step(); wr_en = 1; addr = 0; wr_data = 8'hC0; irq_ack = 1;
        step(); wr_en = 0; irq_ack = 0;
        @(negedge clk);
        check(rd_data[7] == 0 && irq_req == 0, "R9 ack clears gie", rd_data, 8'h40);

        // mixed random traffic checked against the model each cycle
        for (int i = 0; i < 3000; i++) begin
            step();
            ext_pin    = ($urandom % 8) == 0 ? ~ext_pin : ext_pin;
            tmr_ovf    = ($urandom % 16) == 0;
            port_chg   = ($urandom % 16) == 0;
            periph_set = ($urandom % 8) == 0 ? NP'($urandom) : '0;
            wr_en      = ($urandom % 6) == 0;
            addr       = 2'($urandom);
            wr_data    = 8'($urandom);
            irq_ack    = irq_req && (($urandom % 3) == 0);
        end
        step(); wr_en = 0; irq_ack = 0;
        @(negedge clk);
        check(vector_addr == 13'h0004, "R11 vector after traffic", vector_addr, 4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule